// File: doc/BRIEF.md
# Full-bridge gate control logic

This block is the synchronous control logic for an H-bridge made of two half-bridge legs, A and B. Each leg takes a high-side and a low-side command and produces a registered high-side and low-side gate enable. Within a leg the low-side command wins over the high-side command, so the two switches of a leg are never asked to conduct together. Holding the high-side command high puts the leg in complementary mode: the low-side command alone then steers both switches in opposite phase.

Every gate turn-on waits a programmable number of clock cycles (the dead time), while every turn-off acts on the next clock. The dead time comes from an input word that is sampled at the start of each turn-on request. A request that drops before its delay has run out restarts the wait, so short glitches never reach a gate. A shared disable input and a shared undervoltage flag each force all four gates off.

Top module: `fbridge_gate_ctrl`

## Requirements
- R1: While rst_n is low, all four gate outputs are low.
- R2: After a clock edge that samples disable high, all four gate outputs are low, whatever the command inputs are.
- R3: After a clock edge that samples undervoltage high, all four gate outputs are low, whatever the command inputs are.
- R4: In a leg whose low-side command is high, the high-side gate is low after the next edge and the low-side gate follows its own command.
- R5: With the high-side command held high, the low-side gate follows the low-side command and the high-side gate follows its inverse, each turn-on delayed by the dead time.
- R6: A gate request (high-side: high command and low-side command low; low-side: low command high; both with disable and undervoltage low) first sampled at edge k with dead time D drives the gate high after edge k+D and holds it while the request stays; D=0 turns it on after edge k.
- R7: A gate goes low after the first edge that samples its request low, with no added delay.
- R8: The dead time is sampled only at the first edge of a request; changes during the wait do not shorten or lengthen it.
- R9: A request that drops before its wait ends produces no gate pulse, and the next request waits a full dead time again.
- R10: The two legs are independent: commands of one leg never change the gates of the other.
- R11: The high-side and low-side gates of one leg are never high in the same cycle.
- R12: After reset is released, each gate waits a full dead time before its first turn-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis | input | 1 | Global disable, forces all gates low |
| uv | input | 1 | Undervoltage flag, forces all gates low |
| dead_cycles | input | DW | Turn-on delay in clock cycles |
| cmd_ah | input | 1 | Leg A high-side command |
| cmd_al | input | 1 | Leg A low-side command |
| cmd_bh | input | 1 | Leg B high-side command |
| cmd_bl | input | 1 | Leg B low-side command |
| gate_ah | output | 1 | Leg A high-side gate enable |
| gate_al | output | 1 | Leg A low-side gate enable |
| gate_bh | output | 1 | Leg B high-side gate enable |
| gate_bl | output | 1 | Leg B low-side gate enable |

## Verification
A wrong counter value or a stuck wait flag shows at a gate as a turn-on one or more cycles early or late, visible at the first request after the fault, so the bench compares every gate on every cycle against a model that counts consecutive request cycles. A wrong priority or a missed kill shows after a single edge as a gate high when it must be low, and the overlap check catches a leg with both gates on in that same cycle. Directed runs aim at the restart after a glitch, the dead-time value latched at request start, and the first turn-on after reset, where an off-by-one stays hidden under random stimulus.

// File: rtl/fbridge_gate_ctrl.sv
module fbridge_gate_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dis,
  input  logic          uv,
  input  logic [DW-1:0] dead_cycles,
  input  logic          cmd_ah,
  input  logic          cmd_al,
  input  logic          cmd_bh,
  input  logic          cmd_bl,
  output logic          gate_ah,
  output logic          gate_al,
  output logic          gate_bh,
  output logic          gate_bl
);
  localparam int NOUT = 4;

  logic            kill;
  logic [NOUT-1:0] req;
  logic [NOUT-1:0] gate;

  assign kill   = dis | uv;
  assign req[0] = ~kill & cmd_ah & ~cmd_al;
  assign req[1] = ~kill & cmd_al;
  assign req[2] = ~kill & cmd_bh & ~cmd_bl;
  assign req[3] = ~kill & cmd_bl;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic          on_q;
    logic          wait_q;
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q   <= 1'b0;
        wait_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!req[i]) begin
        on_q   <= 1'b0;
        wait_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!on_q) begin
        if (!wait_q) begin
          if (dead_cycles == '0) begin
            on_q <= 1'b1;
          end else begin
            wait_q <= 1'b1;
            cnt_q  <= dead_cycles - 1'b1;
          end
        end else if (cnt_q == '0) begin
          on_q   <= 1'b1;
          wait_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end

    assign gate[i] = on_q;
  end

  assign gate_ah = gate[0];
  assign gate_al = gate[1];
  assign gate_bh = gate[2];
  assign gate_bl = gate[3];
endmodule

module fbridge_gate_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dis,
  input logic          uv,
  input logic [DW-1:0] dead_cycles,
  input logic          cmd_ah,
  input logic          cmd_al,
  input logic          cmd_bh,
  input logic          cmd_bl,
  input logic          gate_ah,
  input logic          gate_al,
  input logic          gate_bh,
  input logic          gate_bl
);
  always_comb begin
    if (!rst_n) assert_reset_low_R1: assert (!gate_ah && !gate_al && !gate_bh && !gate_bl);
  end

  assert_dis_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (!gate_ah && !gate_al && !gate_bh && !gate_bl));

  assert_uv_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (!gate_ah && !gate_al && !gate_bh && !gate_bl));

  assert_low_wins_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_al |=> !gate_ah);
  assert_low_wins_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bl |=> !gate_bh);

  assert_rise_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_al) |-> $past(cmd_al && !dis && !uv));

  assert_fast_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_al && !cmd_bl) |=> (!gate_al && !gate_bl));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ah && gate_al) && !(gate_bh && gate_bl));
endmodule

bind fbridge_gate_ctrl fbridge_gate_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .dis(dis), .uv(uv), .dead_cycles(dead_cycles),
  .cmd_ah(cmd_ah), .cmd_al(cmd_al), .cmd_bh(cmd_bh), .cmd_bl(cmd_bl),
  .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
);

// File: tb/fbridge_gate_ctrl_tb_top.sv
module fbridge_gate_ctrl_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dis = 1'b0, uv = 1'b0;
  logic [DW-1:0] dead_cycles = '0;
  logic cmd_ah = 1'b0, cmd_al = 1'b0, cmd_bh = 1'b0, cmd_bl = 1'b0;
  logic gate_ah, gate_al, gate_bh, gate_bl;

  int checks = 0;
  int fails  = 0;
  int run_len [4];
  int dlat    [4];
  logic exp_g [4];

  always #2 clk = ~clk;

  fbridge_gate_ctrl #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dis(dis), .uv(uv), .dead_cycles(dead_cycles),
    .cmd_ah(cmd_ah), .cmd_al(cmd_al), .cmd_bh(cmd_bh), .cmd_bl(cmd_bl),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
  );

  function automatic logic want(input int idx);
    logic off = dis | uv;
    case (idx)
      0: return !off && cmd_ah && !cmd_al;
      1: return !off && cmd_al;
      2: return !off && cmd_bh && !cmd_bl;
      default: return !off && cmd_bl;
    endcase
  endfunction

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      run_len[i] = 0; dlat[i] = 0; exp_g[i] = 1'b0;
    end
  endtask

  task automatic step(input string tag);
    logic w [4];
    for (int i = 0; i < 4; i++) w[i] = want(i);
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (w[i]) begin
        if (run_len[i] == 0) dlat[i] = int'(dead_cycles);
        run_len[i]++;
        exp_g[i] = (run_len[i] >= dlat[i] + 1);
      end else begin
        run_len[i] = 0;
        exp_g[i] = 1'b0;
      end
    end
    #1;
    chk(tag, "gate_ah", gate_ah, exp_g[0]);
    chk(tag, "gate_al", gate_al, exp_g[1]);
    chk(tag, "gate_bh", gate_bh, exp_g[2]);
    chk(tag, "gate_bl", gate_bl, exp_g[3]);
  endtask

  task automatic set_cmd(input logic ah, input logic al, input logic bh, input logic bl);
    cmd_ah = ah; cmd_al = al; cmd_bh = bh; cmd_bl = bl;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed = 32'h1bad5eed;
    int hold;
    void'($urandom(seed));
    model_clear();

    // R1: outputs low under reset even with commands active
    dead_cycles = 8'd0;
    set_cmd(1, 0, 0, 1);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "gate_ah", gate_ah, 1'b0);
    chk("R1", "gate_bl", gate_bl, 1'b0);
    set_cmd(0, 0, 0, 0);

    // R12: first turn-on after release waits full dead time (D=4: high after 5th edge)
    dead_cycles = 8'd4;
    rst_n = 1'b1;
    set_cmd(0, 1, 0, 0);
    for (int n = 1; n <= 6; n++) begin
      step("R12");
      chk("R12", "gate_al_timing", gate_al, n >= 5);
    end

    // R7: turn-off on the first edge that samples the request low
    set_cmd(0, 0, 0, 0);
    step("R7");
    chk("R7", "gate_al_off", gate_al, 1'b0);

    // R6: D=0 turns on at the first edge
    dead_cycles = 8'd0;
    set_cmd(1, 0, 0, 0);
    step("R6");
    chk("R6", "gate_ah_d0", gate_ah, 1'b1);
    set_cmd(0, 0, 0, 0);
    step("R7");

    // R8: dead time latched at request start, later changes ignored
    dead_cycles = 8'd6;
    set_cmd(0, 0, 1, 0);
    step("R8");
    dead_cycles = 8'd0;
    for (int n = 2; n <= 8; n++) begin
      step("R8");
      chk("R8", "gate_bh_latched", gate_bh, n >= 7);
    end
    set_cmd(0, 0, 0, 0);
    step("R7");

    // R9: glitches shorter than the dead time never pulse
    dead_cycles = 8'd5;
    for (int g = 0; g < 3; g++) begin
      set_cmd(0, 0, 0, 1);
      repeat (3) step("R9");
      chk("R9", "gate_bl_glitch", gate_bl, 1'b0);
      set_cmd(0, 0, 0, 0);
      step("R9");
    end
    set_cmd(0, 0, 0, 1);
    for (int n = 1; n <= 6; n++) begin
      step("R9");
      chk("R9", "gate_bl_restart", gate_bl, n >= 6);
    end

    // R4: low-side command wins inside a leg
    dead_cycles = 8'd1;
    set_cmd(1, 1, 1, 1);
    repeat (4) step("R4");
    chk("R4", "gate_ah_overridden", gate_ah, 1'b0);
    chk("R4", "gate_al_follows", gate_al, 1'b1);

    // R5: complementary mode, high-side held high, low-side toggles
    dead_cycles = 8'd2;
    for (int t = 0; t < 6; t++) begin
      set_cmd(1, t[0], 1, ~t[0]);
      repeat (4) step("R5");
      chk("R5", "gate_ah_inverse", gate_ah, ~t[0]);
      chk("R5", "gate_al_follow", gate_al, t[0]);
    end

    // R2 and R3: kill inputs force everything low
    dis = 1'b1;
    step("R2");
    chk("R2", "gate_ah", gate_ah, 1'b0);
    chk("R2", "gate_bl", gate_bl, 1'b0);
    dis = 1'b0;
    repeat (4) step("R2");
    uv = 1'b1;
    step("R3");
    chk("R3", "gate_ah", gate_ah, 1'b0);
    chk("R3", "gate_bl", gate_bl, 1'b0);
    uv = 1'b0;
    repeat (4) step("R3");

    // R10: leg B toggles while leg A stays on
    dead_cycles = 8'd1;
    set_cmd(0, 1, 0, 0);
    repeat (3) step("R10");
    for (int t = 0; t < 8; t++) begin
      set_cmd(0, 1, t[1], t[0]);
      step("R10");
      chk("R10", "gate_al_steady", gate_al, 1'b1);
      chk("R10", "gate_ah_steady", gate_ah, 1'b0);
    end

    // R6: random stimulus against the cycle-count model
    for (int n = 0; n < 600; n++) begin
      dead_cycles = DW'($urandom_range(0, 5));
      set_cmd($urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 1));
      dis = ($urandom_range(0, 19) == 0);
      uv  = ($urandom_range(0, 29) == 0);
      hold = $urandom_range(1, 9);
      for (int h = 0; h < hold; h++) step((dis || uv) ? "R2" : "R6");
    end
    dis = 1'b0; uv = 1'b0;

    finish_run();
  end
endmodule